// File: doc/BRIEF.md
# Packet Presence Detector Pair

This block sits behind a receive slicer and watches the sampled demodulator output. It reports two things about the incoming burst. The first is whether a signal is present: the slicer's upper and lower tracked data levels have moved far enough apart. The second is whether the packet has ended: the sample has stayed near the middle of those two levels for several bit periods.

The two tracked levels come in as ports; this block does not track them itself. A bit-rate strobe sets the time base for the dwell measurement. A receive/transmit mode input and a separate enable for each detector decide when each one runs. Both flags are registered. The presence flag follows the level spread after one clock. The end flag sets only after a sustained dwell near mid-level. It drops on the next clock edge once the sample moves toward either level.

Top module: `pkt_presence_det`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first edge after it, both `env_flag` and `eop_flag` are 0.
- R2: With `rx_mode` = 0 (transmit), both flags are 0 from the next edge on, and any accumulated dwell is discarded.
- R3: Each detector obeys only its own enable. With `env_en` = 0, `env_flag` is 0 from the next edge. With `eop_en` = 0, `eop_flag` is 0 from the next edge. Neither enable affects the other detector.
- R4: In receive mode with `env_en` = 1, `env_flag` is 1 one edge after a cycle in which `ref_hi - ref_lo` is strictly greater than `ENV_MIN_SPREAD` (default 164 sample units), and 0 otherwise. A spread exactly equal to the threshold gives 0.
- R5: `env_flag` depends only on the two reference levels. The sample value has no effect on it.
- R6: A sample is inside the mid-level window when |4*sample - 2*(ref_hi + ref_lo)| < (ref_hi - ref_lo), that is, within a quarter of the spread of the midpoint. A sample on the boundary is outside. When the spread is zero or negative, no sample is inside.
- R7: An edge with `bit_stb` = 1, a sample inside the window, receive mode and `eop_en` = 1 advances the dwell count by one. `eop_flag` becomes 1 on the edge where the count reaches `DWELL_BITS` (default 4).
- R8: A cycle whose sample is outside the window clears the dwell count, and `eop_flag` is 0 from the next edge.
- R9: Cycles without `bit_stb` do not advance the dwell count. Once the count reaches `DWELL_BITS` it saturates, and `eop_flag` stays 1 for as long as the sample stays inside the window.
- R10: Dropping `eop_en` or leaving receive mode for even one cycle resets the dwell. After that, the full `DWELL_BITS` strobes are needed again before `eop_flag` sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| env_en | input | 1 | Enable for the presence (envelope) detector |
| eop_en | input | 1 | Enable for the end-of-packet detector |
| bit_stb | input | 1 | One-cycle strobe per received bit period |
| sample | input | SAMPLE_W | Signed demodulator sample |
| ref_hi | input | SAMPLE_W | Signed upper tracked data level |
| ref_lo | input | SAMPLE_W | Signed lower tracked data level |
| env_flag | output | 1 | Registered signal-present flag |
| eop_flag | output | 1 | Registered end-of-packet flag |

## Verification
The assertions assume that `bit_stb` is a single-cycle pulse and that the control and data inputs hold steady across each rising edge. They also assume `rst` is high from time zero for at least one edge. The stimulus changes every input a fixed delay after the rising edge and pulses the strobe for one cycle out of every four. It holds reset for several edges at the start. Reference levels are chosen so that the spread and the window stay well inside the sample width. Boundary cases sit exactly at the thresholds.

// File: rtl/pkt_det_pkg.sv
package pkt_det_pkg;

  // Extra headroom bits used for the scaled window arithmetic.
  localparam int unsigned HEADROOM = 4;

  typedef enum logic [1:0] {
    DWELL_IDLE  = 2'd0,
    DWELL_COUNT = 2'd1,
    DWELL_DONE  = 2'd2
  } dwell_state_e;

endpackage

// File: rtl/pkt_win_cmp.sv
module pkt_win_cmp #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] ref_hi,
  input  logic signed [SAMPLE_W-1:0] ref_lo,
  output logic signed [SAMPLE_W+pkt_det_pkg::HEADROOM-1:0] spread,
  output logic                       in_win
);
  localparam int unsigned EW = SAMPLE_W + pkt_det_pkg::HEADROOM;

  logic signed [EW-1:0] s_x, h_x, l_x;
  logic signed [EW-1:0] s4, sum2, dev, dev_abs;

  always_comb begin
    s_x     = EW'(sample);
    h_x     = EW'(ref_hi);
    l_x     = EW'(ref_lo);
    spread  = h_x - l_x;
    s4      = s_x <<< 2;
    sum2    = (h_x + l_x) <<< 1;
    dev     = s4 - sum2;
    dev_abs = dev[EW-1] ? -dev : dev;
    in_win  = (dev_abs < spread);
  end
endmodule

// File: rtl/pkt_env_det.sv
module pkt_env_det #(
  parameter int unsigned SAMPLE_W       = 12,
  parameter int          ENV_MIN_SPREAD = 164
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic signed [SAMPLE_W+pkt_det_pkg::HEADROOM-1:0] spread,
  output logic env_flag
);
  localparam int unsigned EW = SAMPLE_W + pkt_det_pkg::HEADROOM;
  localparam logic signed [EW-1:0] THRESH = EW'(ENV_MIN_SPREAD);

  logic wide;
  assign wide = (spread > THRESH);

  always_ff @(posedge clk) begin
    if (rst) env_flag <= 1'b0;
    else     env_flag <= active & wide;
  end
endmodule

// File: rtl/pkt_eop_dwell.sv
module pkt_eop_dwell #(
  parameter int unsigned DWELL_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic in_win,
  input  logic bit_stb,
  output logic eop_flag
);
  import pkt_det_pkg::*;
  localparam int unsigned CNT_W = $clog2(DWELL_BITS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  dwell_state_e     st_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!active || !in_win)
      cnt_d = '0;
    else if (bit_stb && cnt_q != LIMIT)
      cnt_d = cnt_q + 1'b1;
    if (cnt_d == LIMIT)      st_d = DWELL_DONE;
    else if (cnt_d != '0)    st_d = DWELL_COUNT;
    else                     st_d = DWELL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      eop_flag <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      eop_flag <= (st_d == DWELL_DONE);
    end
  end
endmodule

// File: rtl/pkt_presence_det.sv
module pkt_presence_det #(
  parameter int unsigned SAMPLE_W       = 12,
  parameter int          ENV_MIN_SPREAD = 164,
  parameter int unsigned DWELL_BITS     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_mode,
  input  logic                       env_en,
  input  logic                       eop_en,
  input  logic                       bit_stb,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] ref_hi,
  input  logic signed [SAMPLE_W-1:0] ref_lo,
  output logic                       env_flag,
  output logic                       eop_flag
);
  localparam int unsigned EW = SAMPLE_W + pkt_det_pkg::HEADROOM;

  logic signed [EW-1:0] spread;
  logic                 in_win;

  pkt_win_cmp #(.SAMPLE_W(SAMPLE_W)) u_win (
    .sample (sample),
    .ref_hi (ref_hi),
    .ref_lo (ref_lo),
    .spread (spread),
    .in_win (in_win)
  );

  pkt_env_det #(.SAMPLE_W(SAMPLE_W), .ENV_MIN_SPREAD(ENV_MIN_SPREAD)) u_env (
    .clk      (clk),
    .rst      (rst),
    .active   (rx_mode & env_en),
    .spread   (spread),
    .env_flag (env_flag)
  );

  pkt_eop_dwell #(.DWELL_BITS(DWELL_BITS)) u_eop (
    .clk      (clk),
    .rst      (rst),
    .active   (rx_mode & eop_en),
    .in_win   (in_win),
    .bit_stb  (bit_stb),
    .eop_flag (eop_flag)
  );
endmodule

// File: rtl/pkt_presence_chk.sv
module pkt_presence_chk #(
  parameter int unsigned SAMPLE_W       = 12,
  parameter int          ENV_MIN_SPREAD = 164
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rx_mode,
  input logic                       env_en,
  input logic                       eop_en,
  input logic                       bit_stb,
  input logic signed [SAMPLE_W-1:0] ref_hi,
  input logic signed [SAMPLE_W-1:0] ref_lo,
  input logic                       env_flag,
  input logic                       eop_flag
);
  logic signed [SAMPLE_W+1:0] gap;
  assign gap = (SAMPLE_W+2)'(ref_hi) - (SAMPLE_W+2)'(ref_lo);

  p_tx_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_mode |=> (!env_flag && !eop_flag));

  p_env_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !env_en |=> !env_flag);

  p_eop_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !eop_en |=> !eop_flag);

  p_env_wide_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && env_en && gap > ENV_MIN_SPREAD) |=> env_flag);

  p_env_narrow_r4: assert property (@(posedge clk) disable iff (rst)
    (gap <= ENV_MIN_SPREAD) |=> !env_flag);

  p_eop_rise_on_stb_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(eop_flag) |-> $past(bit_stb));

  p_eop_no_stb_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!bit_stb && !eop_flag) |=> !eop_flag);
endmodule

bind pkt_presence_det pkt_presence_chk #(
  .SAMPLE_W(SAMPLE_W), .ENV_MIN_SPREAD(ENV_MIN_SPREAD)
) u_chk (
  .clk(clk), .rst(rst), .rx_mode(rx_mode), .env_en(env_en), .eop_en(eop_en),
  .bit_stb(bit_stb), .ref_hi(ref_hi), .ref_lo(ref_lo),
  .env_flag(env_flag), .eop_flag(eop_flag)
);

// File: tb/pkt_presence_det_tb.sv
module pkt_presence_det_tb;
  localparam int SW = 12;
  localparam int MIN_SPREAD = 164;
  localparam int DWELL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_mode = 1'b0, env_en = 1'b0, eop_en = 1'b0, bit_stb = 1'b0;
  logic signed [SW-1:0] sample = '0, ref_hi = '0, ref_lo = '0;
  logic env_flag, eop_flag;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";
  bit done = 1'b0;
  int phase = 0;

  // model state
  int  m_cnt = 0;
  bit  m_env = 1'b0, m_eop = 1'b0;

  always #4 clk = ~clk;

  pkt_presence_det #(.SAMPLE_W(SW), .ENV_MIN_SPREAD(MIN_SPREAD), .DWELL_BITS(DWELL)) u_dut (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .env_en(env_en), .eop_en(eop_en),
    .bit_stb(bit_stb), .sample(sample), .ref_hi(ref_hi), .ref_lo(ref_lo),
    .env_flag(env_flag), .eop_flag(eop_flag)
  );

  function automatic bit inside_mid(int s, int h, int l);
    int d;
    d = 4*s - 2*(h+l);
    if (d < 0) d = -d;
    return d < (h - l);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_env = 0; m_eop = 0;
    end else begin
      m_env = rx_mode && env_en && ((int'(ref_hi) - int'(ref_lo)) > MIN_SPREAD);
      if (!(rx_mode && eop_en) || !inside_mid(int'(sample), int'(ref_hi), int'(ref_lo)))
        m_cnt = 0;
      else if (bit_stb && m_cnt < DWELL)
        m_cnt = m_cnt + 1;
      m_eop = (m_cnt >= DWELL);
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (phase > 0) begin
      check(cur_req, "env_flag vs model", env_flag, m_env);
      check(cur_req, "eop_flag vs model", eop_flag, m_eop);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  // one bit period: strobe on first cycle of four
  task automatic bits(int n);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1'b1; step(1);
      bit_stb = 1'b0; step(3);
    end
  endtask

  task automatic probe(string req, string what, bit exp_env, bit exp_eop);
    @(negedge clk);
    check(req, {what, " env"}, env_flag, exp_env);
    check(req, {what, " eop"}, eop_flag, exp_eop);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    cur_req = "R1"; phase = 1;
    probe("R1", "in reset", 1'b0, 1'b0);
    rx_mode = 1; env_en = 1; eop_en = 1;
    ref_hi = 400; ref_lo = -400; sample = 0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", "first edge after reset env", env_flag, 1'b0);
    #2;
    rst = 1'b1; step(2); rst = 1'b0; step(1);

    // R4 threshold
    cur_req = "R4";
    ref_hi = 100; ref_lo = -64; step(2);
    probe("R4", "spread equal threshold", 1'b0, eop_flag);
    ref_lo = -65; step(1);
    probe("R4", "spread above threshold", 1'b1, eop_flag);

    // R5 amplitude independence
    cur_req = "R5";
    ref_hi = 50; ref_lo = -50; sample = 2000; step(2);
    probe("R5", "big sample small spread", 1'b0, 1'b0);
    ref_hi = 600; ref_lo = -600; sample = -2000; step(2);
    probe("R5", "big spread", 1'b1, 1'b0);

    // R6 / R7 dwell inside window (|s| < 200 for +/-400)
    cur_req = "R6";
    ref_hi = 400; ref_lo = -400; sample = 200; bits(6);
    probe("R6", "boundary outside", 1'b1, 1'b0);
    cur_req = "R7";
    sample = 199; bits(3);
    probe("R7", "three bits", 1'b1, 1'b0);
    bits(1);
    probe("R7", "four bits", 1'b1, 1'b1);

    // R9 saturation and no-strobe behaviour
    cur_req = "R9";
    bits(5);
    probe("R9", "saturated hold", 1'b1, 1'b1);
    sample = 300; step(1);
    sample = 0; step(20);
    probe("R9", "no strobes", 1'b1, 1'b0);

    // R8 leaving window
    cur_req = "R8";
    bits(4);
    sample = -250; step(1);
    probe("R8", "left window", 1'b1, 1'b0);
    sample = 0; bits(2); sample = 220; step(1); sample = 0; bits(3);
    probe("R8", "dwell restarted", 1'b1, 1'b0);

    // R10 disable mid-dwell
    cur_req = "R10";
    bits(4); bits(3);
    eop_en = 0; step(1); eop_en = 1; bits(3);
    probe("R10", "after eop_en blip", 1'b1, 1'b0);
    bits(1);
    probe("R10", "refilled", 1'b1, 1'b1);
    rx_mode = 0; step(1); rx_mode = 1; bits(3);
    probe("R10", "after tx blip", 1'b1, 1'b0);

    // R3 independent enables
    cur_req = "R3";
    env_en = 0; bits(4);
    probe("R3", "env off eop on", 1'b0, 1'b1);
    env_en = 1; eop_en = 0; step(2);
    probe("R3", "eop off env on", 1'b1, 1'b0);

    // R6 non-positive spread
    cur_req = "R6";
    eop_en = 1; ref_hi = -100; ref_lo = 100; sample = 0; bits(5);
    probe("R6", "inverted refs", 1'b0, 1'b0);

    // R2 transmit
    cur_req = "R2";
    ref_hi = 400; ref_lo = -400; bits(4);
    rx_mode = 0; step(1);
    probe("R2", "transmit", 1'b0, 1'b0);
    bits(5);
    probe("R2", "transmit strobes", 1'b0, 1'b0);

    done = 1'b1;
    phase = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule